// File: doc/BRIEF.md
# Stop-Mode Wakeup Clock Sequencer

This block decides how the core gets its clock back after a low-power stop. It accepts a full-stop request and a pseudo-stop request. Both are decoded the same way by three configuration inputs: a limp-home disable bit, a clock-monitor enable bit and a delay enable bit. From these bits the block picks one exit path. It can wake at once on the oscillator. It can wake at once on the backup VCO (limp-home). It can wait a stabilization count before waking, and that count runs on slow-divided oscillator ticks or on minimum-frequency VCO ticks depending on the mode. It can also refuse to stop and ask for a clock-monitor reset instead.

The oscillator, the VCO, the slow divider and the clock monitor lie outside the block. They appear only as tick and status inputs. The outputs are a clock-select level, a core clock enable, a one-cycle reset request and a stabilization-done flag.

The reset is asynchronous and active low. Its release is synchronized inside the block.

Top module: `stop_wake_seq`

## Requirements
- R1: After reset the block is running: core_clk_en=1, clk_sel_osc=1 (1 = oscillator, 0 = limp-home VCO), mon_rst_req=0, stab_done=0.
- R2: In the running state, when cfg_lh_off=1 and cfg_mon_en=1, a stop_req or pstop_req raises mon_rst_req for exactly one cycle, starting the cycle after the request, whatever cfg_dly_en is. core_clk_en is 0 during that cycle and 1 again in the cycle after it.
- R3: In the running state, in every other configuration, a stop_req or pstop_req drops core_clk_en in the following cycle. It stays 0 until a wake_evt is sampled.
- R4: With cfg_lh_off=1 and cfg_dly_en=1, a wakeup starts a count of 4096 osc_tick pulses, during which vco_tick has no effect. core_clk_en rises, with clk_sel_osc=1, in the cycle after the 4096th osc_tick.
- R5: With cfg_lh_off=0 and cfg_dly_en=1, the 4096-pulse count uses vco_tick, and osc_tick has no effect. The core then runs with clk_sel_osc=0.
- R6: With cfg_lh_off=0 and cfg_dly_en=0, a wakeup sets core_clk_en=1 and clk_sel_osc=0 in the next cycle, whatever cfg_mon_en is.
- R7: While running on the limp-home VCO, clk_sel_osc stays 0 until osc_good is sampled high. It becomes 1 in the following cycle.
- R8: With cfg_lh_off=1, cfg_mon_en=0 and cfg_dly_en=0, a wakeup sets core_clk_en=1 with clk_sel_osc=1 in the next cycle.
- R9: stab_done rises together with core_clk_en when a stabilization count completes. It is cleared in the cycle a stop is entered, so it stays 0 after an exit that had no count.
- R10: A wake_evt while running has no effect. A stop_req or pstop_req while counting or while running on the limp-home VCO is ignored, and the count still completes on schedule.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lh_off | input | 1 | 1 disables limp-home wakeup |
| cfg_mon_en | input | 1 | 1 enables the clock monitor |
| cfg_dly_en | input | 1 | 1 enables the stabilization count |
| stop_req | input | 1 | Full stop request |
| pstop_req | input | 1 | Pseudo-stop request (oscillator kept running) |
| wake_evt | input | 1 | Wakeup event |
| osc_good | input | 1 | Clock monitor reports a good oscillator |
| osc_tick | input | 1 | Tick of the slow-divided oscillator clock |
| vco_tick | input | 1 | Tick of the minimum-frequency VCO reference |
| clk_sel_osc | output | 1 | Core clock source: 1 oscillator, 0 limp-home VCO |
| core_clk_en | output | 1 | Core clock enable |
| mon_rst_req | output | 1 | One-cycle clock-monitor reset request |
| stab_done | output | 1 | Stabilization count completed |

## Verification
Each of the five configuration classes is tried with both request types. This shows whether a path was chosen from the mode bits or from the request kind. On the counting paths, both tick inputs are driven together, one of them held constantly high. A count that uses the wrong tick then finishes thousands of cycles early and is seen at once. A count that ends one tick late or early is caught at the 4095/4096 boundary. Random stretches mix stray wakeups, stop requests during a count and late osc_good pulses against a cycle model built from the requirements.

// File: rtl/swk_pkg.sv
package swk_pkg;
  typedef enum logic [2:0] {
    S_RUN         = 3'd0,
    S_STOPPED     = 3'd1,
    S_WAIT_STABLE = 3'd2,
    S_RUN_LIMP    = 3'd3,
    S_RESET_REQ   = 3'd4
  } swk_state_e;

  typedef struct packed {
    logic go_reset;
    logic limp;
    logic delay;
  } swk_path_t;
endpackage

// File: rtl/swk_rst_sync.sv
module swk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/swk_mode_dec.sv
module swk_mode_dec
  import swk_pkg::*;
(
  input  logic      lh_off,
  input  logic      mon_en,
  input  logic      dly_en,
  output swk_path_t path
);
  // Monitor bit only matters with limp-home disabled; delay bit only
  // matters when no reset is requested.
  always_comb begin
    path.go_reset = lh_off & mon_en;
    path.limp     = ~lh_off;
    path.delay    = dly_en;
  end
endmodule

// File: rtl/swk_stab_cnt.sv
module swk_stab_cnt #(
  parameter int CNT_W = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic use_vco,
  input  logic osc_tick,
  input  logic vco_tick,
  output logic wrap
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tick;

  assign tick = use_vco ? vco_tick : osc_tick;
  assign wrap = run & tick & (cnt_q == CNT_MAX);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4/R5: count frozen between selected ticks
  p_hold_no_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(cnt_q));
  // R4/R5: count starts from zero
  p_clear_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));
endmodule

// File: rtl/stop_wake_seq.sv
module stop_wake_seq
  import swk_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int SYNC_STAGE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_lh_off,
  input  logic cfg_mon_en,
  input  logic cfg_dly_en,
  input  logic stop_req,
  input  logic pstop_req,
  input  logic wake_evt,
  input  logic osc_good,
  input  logic osc_tick,
  input  logic vco_tick,
  output logic clk_sel_osc,
  output logic core_clk_en,
  output logic mon_rst_req,
  output logic stab_done
);
  logic       rst_n_s;
  swk_path_t  path;
  swk_state_e state_q, state_d;
  logic       done_q, done_d;
  logic       stop_any, cnt_run, cnt_wrap;

  swk_rst_sync #(.STAGES(SYNC_STAGE)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  swk_mode_dec u_dec (
    .lh_off(cfg_lh_off), .mon_en(cfg_mon_en), .dly_en(cfg_dly_en), .path(path));

  assign stop_any = stop_req | pstop_req;
  assign cnt_run  = (state_q == S_WAIT_STABLE);

  swk_stab_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n_s), .run(cnt_run), .use_vco(path.limp),
    .osc_tick(osc_tick), .vco_tick(vco_tick), .wrap(cnt_wrap));

  always_comb begin
    state_d = state_q;
    done_d  = done_q;
    case (state_q)
      S_RUN: if (stop_any) begin
        if (path.go_reset) state_d = S_RESET_REQ;
        else begin
          state_d = S_STOPPED;
          done_d  = 1'b0;
        end
      end
      S_RESET_REQ: state_d = S_RUN;
      S_STOPPED: if (wake_evt) begin
        if (path.delay)     state_d = S_WAIT_STABLE;
        else if (path.limp) state_d = S_RUN_LIMP;
        else                state_d = S_RUN;
      end
      S_WAIT_STABLE: if (cnt_wrap) begin
        done_d  = 1'b1;
        state_d = path.limp ? S_RUN_LIMP : S_RUN;
      end
      S_RUN_LIMP: if (osc_good) state_d = S_RUN;
      default: state_d = S_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= S_RUN;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign core_clk_en = (state_q == S_RUN) || (state_q == S_RUN_LIMP);
  assign clk_sel_osc = (state_q != S_RUN_LIMP);
  assign mon_rst_req = (state_q == S_RESET_REQ);
  assign stab_done   = done_q;

  p_rst_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    mon_rst_req |=> (!mon_rst_req && core_clk_en));
  p_rst_gate_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    mon_rst_req |-> !core_clk_en);
  p_stop_gate_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == S_RUN && stop_any && !path.go_reset) |=> (!core_clk_en && !stab_done));
  p_done_exit_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == S_WAIT_STABLE && cnt_wrap) |=> (stab_done && core_clk_en));
  p_limp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == S_RUN_LIMP && !osc_good) |=> !clk_sel_osc);
  p_wake_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == S_RUN && wake_evt && !stop_any) |=> (state_q == S_RUN));
endmodule

// File: tb/sim_stop_wake_seq.sv
module sim_stop_wake_seq;
  localparam int MAXC = 4095;
  typedef enum int {M_RUN, M_STOP, M_WAIT, M_LIMP, M_RST} mst_e;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lh_off = 1'b0, mon_en = 1'b0, dly_en = 1'b0;
  logic stop_r = 1'b0, pstop_r = 1'b0, wake_r = 1'b0, og_r = 1'b0;
  logic ot_r = 1'b0, vt_r = 1'b0;
  logic clk_sel_osc, core_clk_en, mon_rst_req, stab_done;

  int tests = 0, fails = 0, cyc_cnt = 0;
  logic finished = 1'b0;
  mst_e mst = M_RUN;
  int mcnt = 0;
  logic mdone = 1'b0;

  always #4 clk = ~clk;

  stop_wake_seq u0 (
    .clk(clk), .rst_n(rst_n), .cfg_lh_off(lh_off), .cfg_mon_en(mon_en),
    .cfg_dly_en(dly_en), .stop_req(stop_r), .pstop_req(pstop_r),
    .wake_evt(wake_r), .osc_good(og_r), .osc_tick(ot_r), .vco_tick(vt_r),
    .clk_sel_osc(clk_sel_osc), .core_clk_en(core_clk_en),
    .mon_rst_req(mon_rst_req), .stab_done(stab_done));

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 190000 && !finished) begin
      fails++; tests++;
      $display("FAIL watchdog: run did not end (actual %0d cycles, expected fewer)", cyc_cnt);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp, input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  // Requirement-derived cycle model
  task automatic model_step();
    logic tk;
    case (mst)
      M_RUN: if (stop_r || pstop_r) begin
        if (lh_off && mon_en) mst = M_RST;
        else begin mst = M_STOP; mdone = 1'b0; end
      end
      M_RST: mst = M_RUN;
      M_STOP: begin
        mcnt = 0;
        if (wake_r) mst = dly_en ? M_WAIT : (lh_off ? M_RUN : M_LIMP);
      end
      M_WAIT: begin
        tk = lh_off ? ot_r : vt_r;
        if (tk) begin
          if (mcnt == MAXC) begin
            mdone = 1'b1; mst = lh_off ? M_RUN : M_LIMP; mcnt = 0;
          end else mcnt++;
        end
      end
      M_LIMP: if (og_r) mst = M_RUN;
      default: mst = M_RUN;
    endcase
  endtask

  function automatic string tag_of(mst_e s);
    case (s)
      M_RST:  return "R2";
      M_STOP: return "R3";
      M_WAIT: return lh_off ? "R4" : "R5";
      M_LIMP: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic compare_model();
    string t;
    t = tag_of(mst);
    chk(t, core_clk_en, (mst == M_RUN || mst == M_LIMP), "core_clk_en");
    chk(t, clk_sel_osc, (mst != M_LIMP), "clk_sel_osc");
    chk(t, mon_rst_req, (mst == M_RST), "mon_rst_req");
    chk("R9", stab_done, mdone, "stab_done");
  endtask

  task automatic cyc(input logic s, input logic ps, input logic w, input logic og,
                     input logic ot, input logic vt);
    @(negedge clk);
    stop_r = s; pstop_r = ps; wake_r = w; og_r = og; ot_r = ot; vt_r = vt;
    @(posedge clk);
    model_step();
    #1;
    compare_model();
  endtask

  task automatic set_cfg(input logic a, input logic b, input logic c);
    @(negedge clk);
    lh_off = a; mon_en = b; dly_en = c;
  endtask

  initial begin
    void'($urandom(32'h5EED_0C1C));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) cyc(0, 0, 0, 0, 0, 0);
    // R1
    chk("R1", core_clk_en, 1'b1, "core_clk_en after reset");
    chk("R1", clk_sel_osc, 1'b1, "clk_sel_osc after reset");
    chk("R1", mon_rst_req, 1'b0, "mon_rst_req after reset");
    chk("R1", stab_done, 1'b0, "stab_done after reset");

    // R2: monitor-reset path, both request kinds, delay bit either way
    set_cfg(1, 1, 1);
    cyc(1, 0, 0, 0, 0, 0);
    chk("R2", mon_rst_req, 1'b1, "reset pulse on stop");
    chk("R2", core_clk_en, 1'b0, "core off during pulse");
    cyc(0, 0, 0, 0, 0, 0);
    chk("R2", mon_rst_req, 1'b0, "pulse one cycle");
    chk("R2", core_clk_en, 1'b1, "back to run");
    set_cfg(1, 1, 0);
    cyc(0, 1, 0, 0, 0, 0);
    chk("R2", mon_rst_req, 1'b1, "reset pulse on pseudo-stop");
    cyc(0, 0, 0, 0, 0, 0);

    // R3/R6/R7: fast limp recovery, monitor bit set (don't care)
    set_cfg(0, 1, 0);
    cyc(0, 1, 0, 0, 0, 0);
    chk("R3", core_clk_en, 1'b0, "stopped by pseudo-stop");
    cyc(0, 0, 0, 0, 1, 1);
    chk("R3", core_clk_en, 1'b0, "stays stopped without wake");
    cyc(0, 0, 1, 0, 0, 0);
    chk("R6", core_clk_en, 1'b1, "fast limp wake");
    chk("R6", clk_sel_osc, 1'b0, "VCO selected");
    cyc(1, 0, 0, 0, 0, 0);
    chk("R10", core_clk_en, 1'b1, "stop ignored in limp run");
    chk("R7", clk_sel_osc, 1'b0, "VCO held without osc_good");
    cyc(0, 0, 0, 1, 0, 0);
    chk("R7", clk_sel_osc, 1'b1, "osc after osc_good");

    // R8/R9: plain fast wake on oscillator
    set_cfg(1, 0, 0);
    cyc(1, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 0, 0);
    chk("R8", core_clk_en, 1'b1, "fast osc wake");
    chk("R8", clk_sel_osc, 1'b1, "osc selected");
    chk("R9", stab_done, 1'b0, "no count, no done");
    cyc(0, 0, 1, 0, 0, 0);
    chk("R10", core_clk_en, 1'b1, "wake in run ignored");
    chk("R10", mon_rst_req, 1'b0, "wake in run no pulse");

    // R4: oscillator-tick count, VCO ticks constantly high, stray stops
    set_cfg(1, 0, 1);
    cyc(1, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 0, 0);
    for (int i = 0; i < MAXC; i++) cyc(i % 97 == 5, 0, 0, 0, 1, 1);
    chk("R4", core_clk_en, 1'b0, "still off after 4095 osc ticks");
    cyc(0, 0, 0, 0, 0, 1);
    chk("R4", core_clk_en, 1'b0, "vco tick ignored");
    cyc(0, 0, 0, 0, 1, 0);
    chk("R4", core_clk_en, 1'b1, "on after 4096th osc tick");
    chk("R4", clk_sel_osc, 1'b1, "osc selected");
    chk("R9", stab_done, 1'b1, "done after count");

    // R5: VCO-tick count, osc ticks constantly high
    set_cfg(0, 0, 1);
    cyc(0, 1, 0, 0, 0, 0);
    chk("R9", stab_done, 1'b0, "done cleared on stop");
    cyc(0, 0, 1, 0, 0, 0);
    for (int i = 0; i < MAXC; i++) cyc(0, i % 50 == 3, 0, 1, 1, 1);
    chk("R5", core_clk_en, 1'b0, "still off after 4095 vco ticks");
    cyc(0, 0, 0, 0, 1, 0);
    chk("R5", core_clk_en, 1'b0, "osc tick ignored");
    cyc(0, 0, 0, 0, 0, 1);
    chk("R5", core_clk_en, 1'b1, "on after 4096th vco tick");
    chk("R5", clk_sel_osc, 1'b0, "limp VCO selected");
    cyc(0, 0, 0, 1, 0, 0);

    // Random mix against the model
    for (int i = 0; i < 60000; i++) begin
      if (mst == M_RUN && ($urandom % 40) == 0) begin
        @(negedge clk);
        lh_off = $urandom; mon_en = $urandom; dly_en = $urandom;
      end
      cyc(($urandom % 16) == 0, ($urandom % 16) == 0, ($urandom % 24) == 0,
          ($urandom % 8) == 0, $urandom, $urandom);
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule